// File: doc/BRIEF.md
# Serial Register Target with Pointer Auto-Increment

This block is the two-wire serial target for a fuel-gauge register bank. It answers only to a single 7-bit bus address. It never drives the bus itself: it reports when it wants SDA pulled low, and it only samples SCL. A host first writes a command byte that sets an internal register pointer. Any data bytes after that are written into the bank, starting at the pointer. A host reads with a combined transfer: it writes the pointer, issues a repeated START with the read bit set, and then clocks bytes out of the bank.

The pointer steps forward after every written byte and after every read byte that the host acknowledges. One write or one read can therefore cover several neighbouring registers. The register bank itself sits in neighbouring logic and is reached through a pointer output, a one-cycle write strobe and a one-cycle read strobe.

The accumulated charge value spans two registers and can change between the two byte reads. To keep the pair consistent, reading the high byte takes a copy of the live low byte. The low byte that follows in the same transfer returns that copy.

Top module: `gauge_i2c_target`

## Requirements
- R1: After reset the block does not pull SDA low and raises neither the write strobe nor the read strobe.
- R2: A START or repeated START followed by address 7'b1100100 is acknowledged: SDA is pulled low through the ninth clock of that byte. The R/W bit (bit 0, 1 = read) selects the direction.
- R3: A START followed by any other address gets no acknowledge. The block then stays silent, with no acknowledges and no strobes, until the next START.
- R4: In a write, the first byte after the address loads the register pointer. The next byte produces exactly one write strobe, with that pointer on `regAddr` and the byte on `regWrData`, and the byte is acknowledged.
- R5: Each further data byte in the same write is acknowledged and is written to the previous pointer plus one.
- R6: After a repeated START with the read bit set, the block pulses the read strobe and sends the register at the pointer, MSB first. A data 0 is sent by pulling SDA low.
- R7: When the host acknowledges a read byte (SDA low on the ninth clock), the pointer increments and the next register is sent.
- R8: When the host does not acknowledge a read byte, the block releases SDA and sends nothing more in that transfer. The pointer is left on the last register sent, so a following read-only transfer returns that register again.
- R9: Reading pointer 8'h02 (high charge byte) copies `accLoData`. A read of pointer 8'h03 later in the same transfer returns that copy, even if the live low byte has changed. Outside that case, 8'h03 returns the live value.
- R10: The block starts pulling SDA low only after it has seen SCL low. It never creates an SDA falling edge while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as sampled (asynchronous) |
| sdaIn | input | 1 | Bus data line as sampled (asynchronous) |
| sdaOe | output | 1 | 1 = pull SDA low, 0 = release |
| regAddr | output | 8 | Register pointer presented to the bank |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Byte to be written |
| regRdEn | output | 1 | One-cycle read strobe; `regRdData` is taken in the same cycle |
| regRdData | input | 8 | Bank contents at `regAddr` |
| accLoData | input | 8 | Live low byte of the charge counter |

## Verification
A bit counter that is off by one, or a wrong byte-kind state, shows up on the very next ninth clock. The acknowledge then appears or vanishes where it should not, or a write strobe fires with a shifted byte. A pointer that steps at the wrong moment appears as a wrong `regAddr` on the next strobe, or as a wrong byte in the next read, one byte time later. A lost or stale charge snapshot is visible only in the low byte of a high-then-low read. The bench therefore changes the live low byte between those two bytes.

// File: rtl/gauge_i2c_pkg.sv
package gauge_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } busState_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DATA
  } byteKind_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;
    logic setPtr;
    logic wrByte;
    logic incPtr;
    logic txLoad;
    logic txNext;
    logic ackOn;
    logic sdaRel;
    logic snapClr;
  } dpStrobe_t;
endpackage

// File: rtl/gauge_i2c_sync.sv
module gauge_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/gauge_i2c_dp.sv
module gauge_i2c_dp
  import gauge_i2c_pkg::*;
#(
  parameter int               PTR_W       = 8,
  parameter logic [PTR_W-1:0] ACC_HI_PTR  = 8'h02,
  parameter logic [PTR_W-1:0] ACC_LO_PTR  = 8'h03,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         st,
  input  logic [BYTE_W-1:0] regRdData,
  input  logic [BYTE_W-1:0] accLoData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              sdaOe
);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLine, syncLine;
  assign rawLine = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    gauge_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawLine[g]),
      .dout(syncLine[g])
    );
  end

  logic sclS, sdaS, sclD, sdaD;
  assign sclS = syncLine[1];
  assign sdaS = syncLine[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;
  assign sdaBit  = sdaS;

  logic [BYTE_W-1:0] rxShift, txShift, snap, loadByte;
  logic [PTR_W-1:0]  ptr;
  logic              snapValid, oeQ;

  assign loadByte = (ptr == ACC_LO_PTR && snapValid) ? snap : regRdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      snap      <= '0;
      snapValid <= 1'b0;
      ptr       <= '0;
      oeQ       <= 1'b0;
    end else begin
      if (st.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};

      if (st.setPtr)                    ptr <= PTR_W'(rxShift);
      else if (st.wrByte || st.incPtr)  ptr <= ptr + PTR_W'(1);

      if (st.txLoad)      txShift <= loadByte;
      else if (st.txNext) txShift <= {txShift[BYTE_W-2:0], 1'b0};

      if (st.ackOn)       oeQ <= 1'b1;
      else if (st.txLoad) oeQ <= ~loadByte[BYTE_W-1];
      else if (st.txNext) oeQ <= ~txShift[BYTE_W-2];
      else if (st.sdaRel) oeQ <= 1'b0;

      if (st.snapClr) snapValid <= 1'b0;
      else if (st.txLoad) begin
        if (ptr == ACC_HI_PTR) begin
          snap      <= accLoData;
          snapValid <= 1'b1;
        end else if (ptr == ACC_LO_PTR) begin
          snapValid <= 1'b0;
        end
      end
    end
  end

  assign rxByte    = rxShift;
  assign regAddr   = ptr;
  assign regWrEn   = st.wrByte;
  assign regRdEn   = st.txLoad;
  assign regWrData = rxShift;
  assign sdaOe     = oeQ;

  // R10: a new pull-down begins only after SCL was seen low
  a_r10_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclS));

  // R4: a write strobe lasts a single cycle
  a_r4_wr_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R5: after a written byte the pointer has moved on by one
  a_r5_ptr_step_after_write: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regAddr == $past(regAddr) + PTR_W'(1));

  // R9: a low-byte load with a live copy sends the copy
  a_r9_lo_from_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ACC_LO_PTR && snapValid) |=> txShift == $past(snap));
endmodule

// File: rtl/gauge_i2c_ctrl.sv
module gauge_i2c_ctrl
  import gauge_i2c_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1100100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         st
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  busState_e       state, stateN;
  byteKind_e       kind, kindN;
  logic            rnw, rnwN, mAck, mAckN;
  logic [CNT_W-1:0] bitCnt, cntN;

  always_comb begin
    st     = '0;
    stateN = state;
    kindN  = kind;
    rnwN   = rnw;
    mAckN  = mAck;
    cntN   = bitCnt;
    if (startEv) begin
      stateN     = ST_RX;
      kindN      = K_ADDR;
      cntN       = '0;
      st.sdaRel  = 1'b1;
      st.snapClr = 1'b1;
    end else if (stopEv) begin
      stateN     = ST_IDLE;
      st.sdaRel  = 1'b1;
      st.snapClr = 1'b1;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            st.shiftIn = 1'b1;
            cntN       = bitCnt + CNT_W'(1);
          end else if (sclFall && bitCnt == LAST_BIT) begin
            cntN = '0;
            unique case (kind)
              K_ADDR: begin
                if (rxByte[BYTE_W-1:1] == SLAVE_ADDR) begin
                  st.ackOn = 1'b1;
                  rnwN     = rxByte[0];
                  stateN   = ST_RXACK;
                end else begin
                  stateN = ST_IDLE;
                end
              end
              K_CMD: begin
                st.setPtr = 1'b1;
                st.ackOn  = 1'b1;
                stateN    = ST_RXACK;
              end
              default: begin
                st.wrByte = 1'b1;
                st.ackOn  = 1'b1;
                stateN    = ST_RXACK;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            if (kind == K_ADDR && rnw) begin
              st.txLoad = 1'b1;
              cntN      = CNT_W'(1);
              stateN    = ST_TX;
            end else begin
              st.sdaRel = 1'b1;
              stateN    = ST_RX;
              kindN     = (kind == K_ADDR) ? K_CMD : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              st.sdaRel = 1'b1;
              stateN    = ST_TXACK;
            end else begin
              st.txNext = 1'b1;
              cntN      = bitCnt + CNT_W'(1);
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            mAckN     = ~sdaBit;
            st.incPtr = ~sdaBit;
          end else if (sclFall) begin
            if (mAck) begin
              st.txLoad = 1'b1;
              cntN      = CNT_W'(1);
              stateN    = ST_TX;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kind   <= K_ADDR;
      rnw    <= 1'b0;
      mAck   <= 1'b0;
      bitCnt <= '0;
    end else begin
      state  <= stateN;
      kind   <= kindN;
      rnw    <= rnwN;
      mAck   <= mAckN;
      bitCnt <= cntN;
    end
  end

  // R3: an idle target neither acknowledges nor touches the bank
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !startEv) |-> !(st.ackOn || st.wrByte || st.txLoad || st.setPtr));

  // R2: an address acknowledge needs a matching address byte
  a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    (st.ackOn && state == ST_RX && kind == K_ADDR) |-> rxByte[BYTE_W-1:1] == SLAVE_ADDR);

  // R8: once a read byte is refused, the next state is idle
  a_r8_nak_ends_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TXACK && sclFall && !mAck && !startEv && !stopEv) |=> state == ST_IDLE);
endmodule

// File: rtl/gauge_i2c_target.sv
module gauge_i2c_target
  import gauge_i2c_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'b1100100,
  parameter int         PTR_W       = 8,
  parameter logic [PTR_W-1:0] ACC_HI_PTR = 8'h02,
  parameter logic [PTR_W-1:0] ACC_LO_PTR = 8'h03,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  output logic [PTR_W-1:0] regAddr,
  output logic             regWrEn,
  output logic [7:0]       regWrData,
  output logic             regRdEn,
  input  logic [7:0]       regRdData,
  input  logic [7:0]       accLoData
);
  dpStrobe_t         st;
  logic              sclRise, sclFall, startEv, stopEv, sdaBit;
  logic [BYTE_W-1:0] rxByte;

  gauge_i2c_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .startEv(startEv),
    .stopEv (stopEv),
    .sdaBit (sdaBit),
    .rxByte (rxByte),
    .st     (st)
  );

  gauge_i2c_dp #(
    .PTR_W      (PTR_W),
    .ACC_HI_PTR (ACC_HI_PTR),
    .ACC_LO_PTR (ACC_LO_PTR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .st       (st),
    .regRdData(regRdData),
    .accLoData(accLoData),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startEv  (startEv),
    .stopEv   (stopEv),
    .sdaBit   (sdaBit),
    .rxByte   (rxByte),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regWrData(regWrData),
    .sdaOe    (sdaOe)
  );
endmodule

// File: tb/gauge_i2c_target_tb.sv
module gauge_i2c_target_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic       mScl = 1'b1;
  logic       mLow = 1'b0;
  logic       sdaOe, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData, accLoData;
  logic       sdaLine;
  assign sdaLine = ~(mLow | sdaOe);

  logic [7:0] bank [16];
  logic       pokeEn = 1'b0;
  logic [3:0] pokeAddr = '0;
  logic [7:0] pokeData = '0;
  assign regRdData = bank[regAddr[3:0]];
  assign accLoData = bank[3];

  gauge_i2c_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .accLoData(accLoData)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) bank[i] <= 8'(i * 17);
      bank[1] <= 8'h3C;
      bank[2] <= 8'h7F;
      bank[3] <= 8'hFF;
      bank[6] <= 8'h00;
    end else if (regWrEn) bank[regAddr[3:0]] <= regWrData;
    else if (pokeEn) bank[pokeAddr] <= pokeData;
  end

  int checks = 0;
  int errors = 0;
  int badPull = 0;

  typedef struct {logic [7:0] a; logic [7:0] d;} wrItem_t;
  wrItem_t wrQ[$];

  // scoreboard monitor: pops one expected write per strobe
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      checks++;
      if (wrQ.size() == 0) begin
        errors++;
        $display("FAIL R3/R4 unexpected write actual=%h:%h expected=none", regAddr, regWrData);
      end else begin
        wrItem_t it;
        it = wrQ.pop_front();
        if (regAddr !== it.a || regWrData !== it.d) begin
          errors++;
          $display("FAIL R4/R5 write actual=%h:%h expected=%h:%h", regAddr, regWrData, it.a, it.d);
        end
      end
    end
  end

  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && sdaOe && !prevOe && mScl) badPull++;
    prevOe <= sdaOe;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    mLow = 1'b0; waitClk(12); mLow = 1'b1; waitClk(12); mScl = 1'b0;
  endtask

  task automatic busReStart();
    waitClk(12); mLow = 1'b0; waitClk(13); mScl = 1'b1;
    waitClk(12); mLow = 1'b1; waitClk(12); mScl = 1'b0;
  endtask

  task automatic busStop();
    waitClk(12); mLow = 1'b1; waitClk(13); mScl = 1'b1;
    waitClk(12); mLow = 1'b0; waitClk(25);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic nak);
    for (int i = 7; i >= 0; i--) begin
      waitClk(12); mLow = ~b[i]; waitClk(13); mScl = 1'b1; waitClk(25); mScl = 1'b0;
    end
    waitClk(12); mLow = 1'b0; waitClk(13); mScl = 1'b1;
    waitClk(12); nak = sdaLine; waitClk(13); mScl = 1'b0;
  endtask

  task automatic writeData(input logic [7:0] a, input logic [7:0] d, output logic nak);
    wrQ.push_back('{a: a, d: d});
    sendByte(d, nak);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitClk(25); mScl = 1'b1; waitClk(12); b[i] = sdaLine; waitClk(13); mScl = 1'b0;
    end
    waitClk(12); mLow = giveAck; waitClk(13); mScl = 1'b1; waitClk(25); mScl = 1'b0;
  endtask

  logic       nak;
  logic [7:0] rd;

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    check("R1 sdaOe after reset", {7'b0, sdaOe}, 8'h00);
    check("R1 write strobe after reset", {7'b0, regWrEn}, 8'h00);
    check("R1 read strobe after reset", {7'b0, regRdEn}, 8'h00);

    // R3: foreign address, then a stray byte, both unacknowledged
    busStart();
    sendByte(8'hA6, nak); check("R3 foreign address nak", {7'b0, nak}, 8'h01);
    sendByte(8'h05, nak); check("R3 stays silent", {7'b0, nak}, 8'h01);
    busStop();

    // R2/R4: single write to register 1
    busStart();
    sendByte(8'hC8, nak); check("R2 own address ack", {7'b0, nak}, 8'h00);
    sendByte(8'h01, nak); check("R4 command ack", {7'b0, nak}, 8'h00);
    writeData(8'h01, 8'h5A, nak); check("R4 data ack", {7'b0, nak}, 8'h00);
    busStop();

    // R5: three bytes from pointer 4
    busStart();
    sendByte(8'hC8, nak);
    sendByte(8'h04, nak);
    writeData(8'h04, 8'h11, nak); check("R5 byte 1 ack", {7'b0, nak}, 8'h00);
    writeData(8'h05, 8'h22, nak); check("R5 byte 2 ack", {7'b0, nak}, 8'h00);
    writeData(8'h06, 8'h33, nak); check("R5 byte 3 ack", {7'b0, nak}, 8'h00);
    busStop();

    // R6: combined read of register 1
    busStart();
    sendByte(8'hC8, nak);
    sendByte(8'h01, nak);
    busReStart();
    sendByte(8'hC9, nak); check("R2 repeated start read ack", {7'b0, nak}, 8'h00);
    readByte(1'b0, rd); check("R6 read register 1", rd, 8'h5A);
    check("R8 released after nak", {7'b0, sdaOe}, 8'h00);
    busStop();

    // R7: read 4,5,6 with acknowledges
    busStart();
    sendByte(8'hC8, nak);
    sendByte(8'h04, nak);
    busReStart();
    sendByte(8'hC9, nak);
    readByte(1'b1, rd); check("R7 first byte", rd, 8'h11);
    readByte(1'b1, rd); check("R7 second byte", rd, 8'h22);
    readByte(1'b0, rd); check("R7 third byte", rd, 8'h33);
    busStop();

    // R8: pointer held after nak, nothing sent after nak
    busStart();
    sendByte(8'hC9, nak);
    readByte(1'b0, rd); check("R8 pointer held", rd, 8'h33);
    readByte(1'b0, rd); check("R8 silent after nak", rd, 8'hFF);
    busStop();

    // R9: coherent high/low charge read while low byte changes
    busStart();
    sendByte(8'hC8, nak);
    sendByte(8'h02, nak);
    busReStart();
    sendByte(8'hC9, nak);
    waitClk(10);
    pokeAddr = 4'd3; pokeData = 8'h00; pokeEn = 1'b1; waitClk(1); pokeEn = 1'b0;
    readByte(1'b1, rd); check("R9 high byte", rd, 8'h7F);
    readByte(1'b0, rd); check("R9 low byte from copy", rd, 8'hFF);
    busStop();

    busStart();
    sendByte(8'hC8, nak);
    sendByte(8'h03, nak);
    busReStart();
    sendByte(8'hC9, nak);
    readByte(1'b0, rd); check("R9 low byte live", rd, 8'h00);
    busStop();

    waitClk(20);
    check("R5 all expected writes seen", 8'(wrQ.size()), 8'h00);
    check("R10 no pull while SCL high", 8'(badPull), 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule